// File: doc/BRIEF.md
# Shared Parallel Bus with Background Contender

This block models a multi-drop parallel bus that a network adapter shares with one other bus master. Two masters, one arbiter and one memory target sit on a common set of lines. The lines are a transaction strobe (`bus_frame_n`), an initiator-ready strobe (`bus_irdy_n`), a target-ready strobe (`bus_trdy_n`) and a single select bit (`bus_ad`). The adapter master moves a burst of data blocks into memory when it is told to. The second master stands for all other devices on the bus. It takes the bus for pseudo-random stretches and leaves it idle for pseudo-random gaps. Both stretch lengths come from an LFSR and stay between parameter bounds.

The strobe and select lines are open lines with a pull-up. The owning master pulls them low and every other agent releases them, so each line is modelled as the AND of what the agents drive. The time from a request to the first data block has three parts. Arbitration takes one cycle on an idle bus. Acquisition takes one cycle, until the granted master pulls the strobe. The memory target then adds its own initial latency. After the first block there are no wait states, and one block moves in every cycle in which both ready strobes are low.

The block is used to study how much buffering the adapter needs when other bus traffic steals cycles. A burst is started with `nic_start` and a length. `nic_beat` marks each block that is moved, and `nic_done` marks the end of the burst.

Top module: `sb_shared_bus`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `arb_gnt` and `arb_req` are zero. `bus_frame_n`, `bus_irdy_n` and `bus_trdy_n` are high, and `nic_busy` is low.
- R2: A grant rises only after a cycle in which `bus_frame_n` was high and no grant was held. At most one grant bit is high at a time. Bit 0 of `arb_req`/`arb_gnt` belongs to the adapter master and bit 1 to the contender.
- R3: When both masters request in an idle cycle with no grant held, the grant goes to the master that did not receive the previous grant. The adapter master is favoured first after reset.
- R4: With the contender quiet and the bus idle, the first `nic_beat` appears 3+TGT_LAT cycles after the clock edge that samples `nic_start`. This is one cycle of arbitration, one of acquisition and TGT_LAT+1 of target latency.
- R5: The memory target responds only to transactions whose `bus_ad` is 0, which is the adapter's. It pulls `bus_trdy_n` low exactly TGT_LAT+1 cycles after `bus_frame_n` first goes low. `bus_ad` equal to 1 selects some other device, and the target never answers it.
- R6: A burst of length L moves exactly L blocks, one in each consecutive cycle, with no wait states. For an adapter transaction `bus_frame_n` stays low for TGT_LAT+1+L cycles.
- R7: `nic_done` pulses for one cycle, 3+TGT_LAT+L cycles after the start edge. In that same cycle the adapter has released `bus_frame_n` and `nic_busy` has fallen.
- R8: `nic_start` has no effect while a burst is in progress, and it has no effect when its length is 0.
- R9: Each contender transaction drives `bus_ad` to 1 and holds `bus_frame_n` low for between BUSY_MIN and BUSY_MAX cycles inclusive. No adapter block moves during a contender transaction.
- R10: Once `cont_en` is low, the contender finishes any transaction it holds and then neither requests nor drives the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_en | input | 1 | Enables background traffic from the contender |
| nic_start | input | 1 | Starts an adapter burst when idle |
| nic_len | input | LEN_W | Burst length in blocks (0 ignored) |
| nic_busy | output | 1 | Adapter burst in progress |
| nic_beat | output | 1 | One block moved this cycle |
| nic_done | output | 1 | Burst finished pulse |
| arb_req | output | 2 | Bus requests (bit 0 adapter, bit 1 contender) |
| arb_gnt | output | 2 | Bus grants (bit 0 adapter, bit 1 contender) |
| bus_frame_n | output | 1 | Open transaction strobe, low while owned |
| bus_irdy_n | output | 1 | Open initiator-ready strobe |
| bus_trdy_n | output | 1 | Open target-ready strobe |
| bus_ad | output | 1 | Target select: 0 memory, 1 other device |

## Verification
The hardest case to reach from the ports is the one where both masters ask for an idle bus in the same cycle, because that is the only case where the round-robin pointer decides the grant. A second hard case is a contender stretch that lands just as an adapter burst wants the bus. The bench first runs timed bursts of every length with the contender off, so that every latency can be predicted exactly. It then turns the contender on and issues a long series of back-to-back adapter bursts, so that request collisions happen often. During this phase it follows every grant edge and every contender stretch at the ports.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int M_NIC     = 0;
  localparam int M_CON     = 1;
  localparam int N_MASTERS = 2;

  localparam logic AD_MEM   = 1'b0;
  localparam logic AD_OTHER = 1'b1;

  typedef enum logic [1:0] {NIC_IDLE, NIC_REQ, NIC_XFER} nic_st_t;
  typedef enum logic [1:0] {CON_GAP, CON_REQ, CON_BUSY} con_st_t;
endpackage

// File: rtl/sb_arbiter.sv
module sb_arbiter #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         frame_n,
  output logic [N-1:0] gnt
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] last_q;
  logic [N-1:0]     pick;
  logic [IDX_W-1:0] pick_idx;
  logic             found;

  // rotating search that starts just after the last winner
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!found && req[(int'(last_q) + k) % N]) begin
        found = 1'b1;
        pick[(int'(last_q) + k) % N] = 1'b1;
        pick_idx = IDX_W'((int'(last_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt    <= '0;
      last_q <= IDX_W'(N - 1);
    end else if (|gnt) begin
      // acquisition done, or the requester withdrew
      if (!frame_n || !(|(gnt & req))) gnt <= '0;
    end else if (frame_n && found) begin
      gnt    <= pick;
      last_q <= pick_idx;
    end
  end
endmodule

// File: rtl/sb_nic_master.sv
module sb_nic_master
  import sb_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             gnt,
  input  logic             bus_irdy_n,
  input  logic             bus_trdy_n,
  output logic             req,
  output logic             frame_drv_n,
  output logic             irdy_drv_n,
  output logic             ad_drv,
  output logic             busy,
  output logic             beat,
  output logic             done
);
  nic_st_t          st_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  assign req  = (st_q == NIC_REQ);
  assign busy = (st_q != NIC_IDLE);
  assign beat = (st_q == NIC_XFER) && !bus_irdy_n && !bus_trdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= NIC_IDLE;
      len_q       <= '0;
      cnt_q       <= '0;
      frame_drv_n <= 1'b1;
      irdy_drv_n  <= 1'b1;
      ad_drv      <= 1'b1;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        NIC_IDLE: begin
          if (start && (len != '0)) begin
            len_q <= len;
            st_q  <= NIC_REQ;
          end
        end
        NIC_REQ: begin
          if (gnt) begin
            frame_drv_n <= 1'b0;
            irdy_drv_n  <= 1'b0;
            ad_drv      <= AD_MEM;
            cnt_q       <= '0;
            st_q        <= NIC_XFER;
          end
        end
        NIC_XFER: begin
          if (beat) begin
            if (cnt_q == len_q - 1'b1) begin
              frame_drv_n <= 1'b1;
              irdy_drv_n  <= 1'b1;
              ad_drv      <= 1'b1;
              done        <= 1'b1;
              st_q        <= NIC_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= NIC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sb_contender.sv
module sb_contender
  import sb_pkg::*;
#(
  parameter int          GAP_MIN   = 2,
  parameter int          GAP_MAX   = 9,
  parameter int          BUSY_MIN  = 3,
  parameter int          BUSY_MAX  = 12,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic gnt,
  output logic req,
  output logic frame_drv_n
);
  localparam int TOP      = (GAP_MAX > BUSY_MAX) ? GAP_MAX : BUSY_MAX;
  localparam int CNT_W    = $clog2(TOP + 1);
  localparam int GAP_SPAN = GAP_MAX - GAP_MIN + 1;
  localparam int BSY_SPAN = BUSY_MAX - BUSY_MIN + 1;

  con_st_t           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [CNT_W-1:0]  gap_len;
  logic [CNT_W-1:0]  bsy_len;

  assign gap_len = CNT_W'(GAP_MIN + (int'(lfsr_q) % GAP_SPAN));
  assign bsy_len = CNT_W'(BUSY_MIN + (int'(lfsr_q) % BSY_SPAN));
  assign req     = (st_q == CON_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= LFSR_SEED[LFSR_W-1:0];
    end else begin
      lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^
                (lfsr_q[0] ? LFSR_TAPS[LFSR_W-1:0] : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= CON_GAP;
      cnt_q       <= CNT_W'(GAP_MIN);
      frame_drv_n <= 1'b1;
    end else begin
      unique case (st_q)
        CON_GAP: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (en)     st_q  <= CON_REQ;
        end
        CON_REQ: begin
          if (gnt) begin
            frame_drv_n <= 1'b0;
            cnt_q       <= bsy_len - 1'b1;
            st_q        <= CON_BUSY;
          end else if (!en) begin
            st_q <= CON_GAP;
          end
        end
        CON_BUSY: begin
          if (cnt_q == '0) begin
            frame_drv_n <= 1'b1;
            cnt_q       <= gap_len;
            st_q        <= CON_GAP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= CON_GAP;
      endcase
    end
  end
endmodule

// File: rtl/sb_mem_target.sv
module sb_mem_target
  import sb_pkg::*;
#(
  parameter int TGT_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic ad,
  output logic trdy_n
);
  localparam int TW = (TGT_LAT > 0) ? $clog2(TGT_LAT + 1) : 1;

  logic          act_q;
  logic [TW-1:0] lat_q;

  assign trdy_n = !(act_q && (lat_q == '0) && !frame_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      lat_q <= '0;
    end else if (!act_q) begin
      if (!frame_n && (ad == AD_MEM)) begin
        act_q <= 1'b1;
        lat_q <= TW'(TGT_LAT);
      end
    end else if (frame_n) begin
      act_q <= 1'b0;
    end else if (lat_q != '0) begin
      lat_q <= lat_q - 1'b1;
    end
  end
endmodule

// File: rtl/sb_shared_bus.sv
module sb_shared_bus
  import sb_pkg::*;
#(
  parameter int          LEN_W     = 4,
  parameter int          TGT_LAT   = 2,
  parameter int          GAP_MIN   = 2,
  parameter int          GAP_MAX   = 9,
  parameter int          BUSY_MIN  = 3,
  parameter int          BUSY_MAX  = 12,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cont_en,
  input  logic             nic_start,
  input  logic [LEN_W-1:0] nic_len,
  output logic             nic_busy,
  output logic             nic_beat,
  output logic             nic_done,
  output logic [1:0]       arb_req,
  output logic [1:0]       arb_gnt,
  output logic             bus_frame_n,
  output logic             bus_irdy_n,
  output logic             bus_trdy_n,
  output logic             bus_ad
);
  logic nic_frame_n, nic_irdy_n, nic_ad;
  logic con_frame_n;

  // open lines with pull-up: any agent pulling low wins
  assign bus_frame_n = nic_frame_n & con_frame_n;
  assign bus_irdy_n  = nic_irdy_n;
  // contender selects the other device, which equals the released level
  assign bus_ad      = nic_ad & (con_frame_n | AD_OTHER);

  sb_arbiter #(.N(N_MASTERS)) u_arb (
    .clk(clk), .rst(rst), .req(arb_req), .frame_n(bus_frame_n), .gnt(arb_gnt)
  );

  sb_nic_master #(.LEN_W(LEN_W)) u_nic (
    .clk(clk), .rst(rst), .start(nic_start), .len(nic_len),
    .gnt(arb_gnt[M_NIC]), .bus_irdy_n(bus_irdy_n), .bus_trdy_n(bus_trdy_n),
    .req(arb_req[M_NIC]), .frame_drv_n(nic_frame_n), .irdy_drv_n(nic_irdy_n),
    .ad_drv(nic_ad), .busy(nic_busy), .beat(nic_beat), .done(nic_done)
  );

  sb_contender #(
    .GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX), .BUSY_MIN(BUSY_MIN),
    .BUSY_MAX(BUSY_MAX), .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS),
    .LFSR_SEED(LFSR_SEED)
  ) u_con (
    .clk(clk), .rst(rst), .en(cont_en), .gnt(arb_gnt[M_CON]),
    .req(arb_req[M_CON]), .frame_drv_n(con_frame_n)
  );

  sb_mem_target #(.TGT_LAT(TGT_LAT)) u_tgt (
    .clk(clk), .rst(rst), .frame_n(bus_frame_n), .ad(bus_ad), .trdy_n(bus_trdy_n)
  );
endmodule

// File: rtl/sb_shared_bus_chk.sv
module sb_shared_bus_chk #(
  parameter int TGT_LAT  = 2,
  parameter int BUSY_MIN = 3,
  parameter int BUSY_MAX = 12
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] arb_req,
  input logic [1:0] arb_gnt,
  input logic       bus_frame_n,
  input logic       bus_trdy_n,
  input logic       bus_ad,
  input logic       nic_beat,
  input logic       nic_done
);
  logic [7:0] low_q;
  logic [1:0] last_g;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= '0;
      last_g <= 2'b10;
    end else begin
      if (bus_frame_n)        low_q <= '0;
      else if (low_q != 8'hFF) low_q <= low_q + 1'b1;
      if (arb_gnt != 2'b00) last_g <= arb_gnt;
    end
  end

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(arb_gnt));

  assert_grant_on_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ((arb_gnt != 2'b00) && ($past(arb_gnt) == 2'b00)) |-> $past(bus_frame_n));

  assert_round_robin_R3: assert property (@(posedge clk) disable iff (rst)
    ((arb_req == 2'b11) && (arb_gnt == 2'b00) && bus_frame_n)
      |=> (arb_gnt == ~$past(last_g)));

  assert_trdy_mem_only_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_trdy_n |-> !bus_ad);

  assert_trdy_latency_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_trdy_n) |-> (low_q == 8'(TGT_LAT + 1)));

  assert_beat_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    nic_beat |-> (!bus_frame_n && !bus_ad));

  assert_done_release_R7: assert property (@(posedge clk) disable iff (rst)
    nic_done |-> bus_frame_n);

  assert_contender_span_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_frame_n) && $past(bus_ad))
      |-> ((low_q >= 8'(BUSY_MIN)) && (low_q <= 8'(BUSY_MAX))));
endmodule

bind sb_shared_bus sb_shared_bus_chk #(
  .TGT_LAT(TGT_LAT), .BUSY_MIN(BUSY_MIN), .BUSY_MAX(BUSY_MAX)
) u_chk (
  .clk(clk), .rst(rst), .arb_req(arb_req), .arb_gnt(arb_gnt),
  .bus_frame_n(bus_frame_n), .bus_trdy_n(bus_trdy_n), .bus_ad(bus_ad),
  .nic_beat(nic_beat), .nic_done(nic_done)
);

// File: tb/test_sb_shared_bus.sv
module test_sb_shared_bus;
  localparam int LEN_W    = 4;
  localparam int TGT_LAT  = 2;
  localparam int BUSY_MIN = 3;
  localparam int BUSY_MAX = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cont_en = 1'b0;
  logic             nic_start = 1'b0;
  logic [LEN_W-1:0] nic_len = '0;
  logic             nic_busy, nic_beat, nic_done;
  logic [1:0]       arb_req, arb_gnt;
  logic             bus_frame_n, bus_irdy_n, bus_trdy_n, bus_ad;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int con_runs = 0;
  int run = 0;
  logic run_ad = 1'b0;
  logic [1:0] p_gnt = 2'b00;
  logic [1:0] p_req = 2'b00;
  logic p_frame_n = 1'b1;
  logic [1:0] last_g = 2'b10;
  int lcg = 7;

  always #5 clk = ~clk;

  sb_shared_bus #(.LEN_W(LEN_W), .TGT_LAT(TGT_LAT),
                  .BUSY_MIN(BUSY_MIN), .BUSY_MAX(BUSY_MAX)) i_sb_shared_bus (
    .clk(clk), .rst(rst), .cont_en(cont_en), .nic_start(nic_start),
    .nic_len(nic_len), .nic_busy(nic_busy), .nic_beat(nic_beat),
    .nic_done(nic_done), .arb_req(arb_req), .arb_gnt(arb_gnt),
    .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
    .bus_trdy_n(bus_trdy_n), .bus_ad(bus_ad)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // port monitor: grants, contender stretches, beats during other traffic
  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_frame_n) begin
        run++;
        run_ad = bus_ad;
      end else if (run > 0) begin
        if (run_ad) begin
          con_runs++;
          check(run >= BUSY_MIN && run <= BUSY_MAX, "R9 contender span", run, BUSY_MIN);
        end
        run = 0;
      end
      if (nic_beat) check(!bus_ad, "R9 beat during other device", int'(bus_ad), 0);
      if (arb_gnt != 2'b00 && p_gnt == 2'b00) begin
        check(p_frame_n == 1'b1, "R2 grant on busy bus", int'(p_frame_n), 1);
        check($countones(arb_gnt) == 1, "R2 one grant", int'(arb_gnt), 1);
        if (p_req == 2'b11)
          check(arb_gnt == ~last_g, "R3 round robin", int'(arb_gnt), int'(~last_g));
        last_g = arb_gnt;
      end
      p_gnt = arb_gnt;
      p_req = arb_req;
      p_frame_n = bus_frame_n;
    end
  end

  task automatic burst(input int len, input bit timed);
    int idx = 0, first = -1, beats = 0, done_idx = -1, flow = 0;
    @(negedge clk);
    nic_start = 1'b1;
    nic_len = LEN_W'(len);
    @(posedge clk);
    @(negedge clk);
    nic_start = 1'b0;
    while (done_idx < 0 && idx < 3000) begin
      if (nic_beat) begin
        beats++;
        if (first < 0) first = idx;
      end
      if (!bus_frame_n && !bus_ad) flow++;
      if (nic_done) done_idx = idx;
      else begin
        idx++;
        @(negedge clk);
      end
    end
    check(beats == len, "R6 block count", beats, len);
    check(done_idx >= 0, "R7 done seen", done_idx, 0);
    if (timed) begin
      check(first == 3 + TGT_LAT, "R4 first block latency", first, 3 + TGT_LAT);
      check(done_idx == 3 + TGT_LAT + len, "R7 done cycle", done_idx, 3 + TGT_LAT + len);
      check(flow == TGT_LAT + 1 + len, "R5 R6 frame length", flow, TGT_LAT + 1 + len);
      check(!nic_busy && bus_frame_n, "R7 released at done", int'(nic_busy), 0);
    end
  endtask

  initial begin
    int beats;
    int busy_seen;
    int con_seen;
    repeat (4) @(negedge clk);
    check(arb_gnt == 2'b00 && arb_req == 2'b00 && bus_frame_n && bus_irdy_n &&
          bus_trdy_n && !nic_busy, "R1 reset state", int'(arb_gnt), 0);
    rst = 1'b0;
    @(negedge clk);
    check(arb_gnt == 2'b00 && bus_frame_n && bus_trdy_n && !nic_busy,
          "R1 after reset", int'(arb_gnt), 0);
    repeat (20) @(negedge clk);

    // timed sweep of every length, contender quiet
    for (int l = 1; l < (1 << LEN_W); l++) begin
      burst(l, 1'b1);
      repeat (3) @(negedge clk);
    end

    // R8: start pulses during a burst are ignored
    beats = 0;
    nic_start = 1'b1;
    nic_len = LEN_W'(5);
    @(negedge clk);
    nic_start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (nic_beat) beats++;
      nic_start = (i == 2 || i == 7);
      nic_len = LEN_W'(9);
      @(negedge clk);
    end
    nic_start = 1'b0;
    check(beats == 5, "R8 start ignored while busy", beats, 5);
    check(!nic_busy, "R8 no extra burst", int'(nic_busy), 0);

    // R8: zero length is ignored
    nic_start = 1'b1;
    nic_len = '0;
    @(negedge clk);
    nic_start = 1'b0;
    busy_seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (nic_busy || !bus_frame_n) busy_seen++;
      @(negedge clk);
    end
    check(busy_seen == 0, "R8 zero length ignored", busy_seen, 0);

    // contention phase
    cont_en = 1'b1;
    for (int b = 0; b < 40; b++) begin
      lcg = lcg * 1103515245 + 12345;
      burst(((lcg >>> 16) & 32'h7fff) % ((1 << LEN_W) - 1) + 1, 1'b0);
    end
    check(con_runs > 0, "R9 contender traffic present", con_runs, 1);

    // R10: disabling stops the contender
    cont_en = 1'b0;
    repeat (40) @(negedge clk);
    con_seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (arb_req[1] || !bus_frame_n) con_seen++;
      @(negedge clk);
    end
    check(con_seen == 0, "R10 contender silent", con_seen, 0);

    // latency holds again on a quiet bus
    burst(4, 1'b1);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule